// File: doc/BRIEF.md
# Interrupt Group Arbiter with Level Vectoring

This block watches a bank of interrupt groups. Each group supplies a pending flag and a 3-bit priority level, where a lower number means a more urgent level. A group takes part in arbitration only when its level is below the 3-bit acceptance mask taken from the processor status word. Among those groups the block picks the one with the smallest group number and registers that choice. The choice is visible in two places: a read-only accept-group register, and a handler start address output.

The block also holds seven 16-bit vector words, one for each level from 0 to 6. The handler address is built from a fixed upper half of 0x4000 and the vector word of the winning group's level as the lower half. Software can also add the accept-group value to the base of a vector table whose entries are 4 bytes apart, because the group number sits at bits 6..2. A small two-state read machine returns each register read one cycle after the request. Its states are RD_IDLE and RD_RESP. The machine goes from RD_IDLE to RD_RESP on a read request. It stays in RD_RESP while further requests arrive back to back. It returns to RD_IDLE on the first cycle with no request.

Top module: `irq_group_vectorer`

## Requirements
- R1: The accept-group register (byte address 0x10) reads `{9'b0, gn[4:0], 2'b00}`, where gn is the lowest-numbered group that is pending at an accepted level.
- R2: A group's level L is accepted when L < mask_i. A level of 7 is therefore never accepted, and a mask of 0 accepts no level.
- R3: When no pending group has an accepted level, the accept-group register reads 0x0000, irq_valid is 0 and handler_addr is 0.
- R4: irq_valid and handler_addr reflect pend_i, lvl_i and mask_i as they were sampled at the previous rising clock edge.
- R5: While irq_valid is 1, handler_addr equals `{16'h4000, V[L]}`, where V[L] is the vector word of the winning group's level L.
- R6: Vector word n (0..6) sits at byte address 2*n. A halfword write (reg_byte=0) stores reg_wdata, and a halfword read returns the stored value.
- R7: A write to the accept-group address has no effect: all vector words stay the same, and the register still reads the arbitration result.
- R8: A byte read (reg_byte=1) returns the addressed byte in reg_rdata[7:0], with the upper byte zero. Address bit 0 selects the lane: 0 picks bits 7..0 and 1 picks bits 15..8.
- R9: A read request (reg_re=1) at a rising edge gives reg_rvalid=1 and the data in the following cycle. reg_rvalid is 0 in the cycle after an edge with no request.
- R10: Byte writes (reg_byte=1) to vector words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | NUM_GROUPS | Pending flag per group |
| lvl_i | input | 3*NUM_GROUPS | Level per group; group g uses bits 3g+2..3g |
| mask_i | input | 3 | Acceptance mask from the processor status word |
| reg_re | input | 1 | Register read request |
| reg_we | input | 1 | Register write request |
| reg_byte | input | 1 | 1 = byte access, 0 = halfword access |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read response strobe |
| irq_valid | output | 1 | An accepted request is pending |
| handler_addr | output | 32 | Handler start address of the winning level |

## Verification
If the acceptance filter or the lowest-number search went wrong, the fault would show one cycle after the inputs settle. It would appear on irq_valid, on the level that handler_addr selects, and on the next accept-group read. A corrupted vector word would show on handler_addr as soon as a group at that level wins, and on a read-back of that word. A fault in the read state machine would show as a missing or extra reg_rvalid in the cycle right after the request edge.

// File: rtl/igv_pkg.sv
package igv_pkg;
    parameter int GN_W  = 5;
    parameter int LVL_W = 3;
    parameter int VEC_W = 16;

    typedef struct packed {
        logic             valid;
        logic [GN_W-1:0]  gn;
        logic [LVL_W-1:0] lvl;
    } win_t;

    typedef enum logic {RD_IDLE, RD_RESP} rd_state_t;
endpackage

// File: rtl/igv_arbiter.sv
module igv_arbiter
    import igv_pkg::*;
#(
    parameter int NUM_GROUPS = 24
) (
    input  logic [NUM_GROUPS-1:0]       pend,
    input  logic [NUM_GROUPS*LVL_W-1:0] lvl_flat,
    input  logic [LVL_W-1:0]            mask,
    output win_t                        win
);
    logic [NUM_GROUPS-1:0] accepted;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_accept
        assign accepted[g] = pend[g] && (lvl_flat[g*LVL_W +: LVL_W] < mask);
    end

    always_comb begin
        win = '0;
        for (int i = NUM_GROUPS - 1; i >= 0; i--) begin
            if (accepted[i]) begin
                win.valid = 1'b1;
                win.gn    = GN_W'(i);
                win.lvl   = lvl_flat[i*LVL_W +: LVL_W];
            end
        end
    end

    // R1: no group below the winner may itself be accepted
    always_comb begin
        for (int i = 0; i < NUM_GROUPS; i++) begin
            if (win.valid && (i < int'(win.gn)))
                p_lowest_wins_r1: assert (!(pend[i] && (lvl_flat[i*LVL_W +: LVL_W] < mask)));
        end
    end
endmodule

// File: rtl/igv_vector_file.sv
module igv_vector_file
    import igv_pkg::*;
#(
    parameter int NUM_LEVELS = 7,
    localparam int IDX_W = $clog2(NUM_LEVELS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [VEC_W-1:0] wdata,
    output logic [VEC_W-1:0] vec [NUM_LEVELS]
);
    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_word
        always_ff @(posedge clk) begin
            if (we && (widx == IDX_W'(l)))
                vec[l] <= wdata;
        end
    end
endmodule

// File: rtl/igv_read_fsm.sv
module igv_read_fsm
    import igv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             re,
    input  logic [VEC_W-1:0] data_in,
    output logic [VEC_W-1:0] rdata,
    output logic             rvalid
);
    rd_state_t        state_q, state_d;
    logic [VEC_W-1:0] data_q;

    always_comb begin
        unique case (state_q)
            RD_IDLE: state_d = re ? RD_RESP : RD_IDLE;
            RD_RESP: state_d = re ? RD_RESP : RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (re) data_q <= data_in;
        end
    end

    always_comb begin
        unique case (state_q)
            RD_RESP: begin rvalid = 1'b1; rdata = data_q; end
            default: begin rvalid = 1'b0; rdata = '0;     end
        endcase
    end

    p_resp_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        re |=> rvalid);
    p_no_resp_unasked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> !rvalid);
endmodule

// File: rtl/irq_group_vectorer.sv
module irq_group_vectorer
    import igv_pkg::*;
#(
    parameter int          NUM_GROUPS = 24,
    parameter int          NUM_LEVELS = 7,
    parameter logic [15:0] ADDR_UPPER = 16'h4000,
    parameter logic [4:0]  ACC_ADDR   = 5'h10
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GROUPS-1:0]       pend_i,
    input  logic [NUM_GROUPS*LVL_W-1:0] lvl_i,
    input  logic [LVL_W-1:0]            mask_i,
    input  logic                        reg_re,
    input  logic                        reg_we,
    input  logic                        reg_byte,
    input  logic [4:0]                  reg_addr,
    input  logic [VEC_W-1:0]            reg_wdata,
    output logic [VEC_W-1:0]            reg_rdata,
    output logic                        reg_rvalid,
    output logic                        irq_valid,
    output logic [31:0]                 handler_addr
);
    localparam int IDX_W = $clog2(NUM_LEVELS);

    win_t             win_d, win_q;
    logic [VEC_W-1:0] vec [NUM_LEVELS];
    logic             is_acc, is_vec;
    logic [IDX_W-1:0] vidx;
    logic [VEC_W-1:0] hw_sel, rd_mux;

    igv_arbiter #(.NUM_GROUPS(NUM_GROUPS)) u_arb (
        .pend(pend_i), .lvl_flat(lvl_i), .mask(mask_i), .win(win_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    // address decode
    assign vidx   = reg_addr[IDX_W:1];
    assign is_acc = (reg_addr[4:1] == ACC_ADDR[4:1]);
    assign is_vec = (reg_addr[4:IDX_W+1] == '0) && (int'(vidx) < NUM_LEVELS);

    igv_vector_file #(.NUM_LEVELS(NUM_LEVELS)) u_vec (
        .clk(clk),
        .we(reg_we && !reg_byte && is_vec && !reg_addr[0]),
        .widx(vidx),
        .wdata(reg_wdata),
        .vec(vec)
    );

    always_comb begin
        if (is_acc)
            hw_sel = {{(VEC_W-GN_W-2){1'b0}}, win_q.gn, 2'b00};
        else if (is_vec)
            hw_sel = vec[vidx];
        else
            hw_sel = '0;
        if (reg_byte)
            rd_mux = {8'h00, reg_addr[0] ? hw_sel[15:8] : hw_sel[7:0]};
        else
            rd_mux = hw_sel;
    end

    igv_read_fsm u_rd (
        .clk(clk), .rst_n(rst_n), .re(reg_re),
        .data_in(rd_mux), .rdata(reg_rdata), .rvalid(reg_rvalid)
    );

    assign irq_valid    = win_q.valid;
    assign handler_addr = (win_q.valid && (int'(win_q.lvl) < NUM_LEVELS))
                          ? {ADDR_UPPER, vec[win_q.lvl[IDX_W-1:0]]} : 32'h0;

    p_level_below_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (win_q.lvl < $past(mask_i)));
    p_empty_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && is_acc && !irq_valid) |=> (reg_rdata == '0));
    p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (handler_addr[31:16] == ADDR_UPPER));

    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_ro
        p_acc_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_we && is_acc) |=> $stable(vec[l]));
    end
endmodule

// File: tb/test_irq_group_vectorer.sv
module test_irq_group_vectorer;
    localparam int NG = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NG-1:0]   pend_i = '0;
    logic [NG*3-1:0] lvl_i = '0;
    logic [2:0]      mask_i = '0;
    logic            reg_re = 1'b0, reg_we = 1'b0, reg_byte = 1'b0;
    logic [4:0]      reg_addr = '0;
    logic [15:0]     reg_wdata = '0;
    logic [15:0]     reg_rdata;
    logic            reg_rvalid, irq_valid;
    logic [31:0]     handler_addr;

    int          n_tests = 0, n_fail = 0;
    logic [15:0] vmodel [7];

    irq_group_vectorer i_irq_group_vectorer (
        .clk, .rst_n, .pend_i, .lvl_i, .mask_i, .reg_re, .reg_we, .reg_byte,
        .reg_addr, .reg_wdata, .reg_rdata, .reg_rvalid, .irq_valid, .handler_addr
    );

    always #2 clk = ~clk;

    initial begin
        #400000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // reference arbitration: returns {valid, gn[4:0], lvl[2:0]}
    function automatic logic [8:0] ref_win(logic [NG-1:0] p, logic [NG*3-1:0] l, logic [2:0] m);
        for (int i = 0; i < NG; i++)
            if (p[i] && (l[i*3 +: 3] < m)) return {1'b1, 5'(i), l[i*3 +: 3]};
        return 9'h0;
    endfunction

    task automatic wr(logic [4:0] a, logic [15:0] d, logic b);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_byte = b;
        tick();
        reg_we = 1'b0; reg_byte = 1'b0;
    endtask

    task automatic rd(logic [4:0] a, logic b, output logic [15:0] d);
        reg_re = 1'b1; reg_addr = a; reg_byte = b;
        tick();
        reg_re = 1'b0; reg_byte = 1'b0;
        check("R9 rvalid", 32'(reg_rvalid), 32'd1);
        d = reg_rdata;
    endtask

    task automatic check_outputs(string tag);
        logic [8:0]  w;
        logic [15:0] d;
        w = ref_win(pend_i, lvl_i, mask_i);
        tick();
        check({tag, " R4 irq_valid"}, 32'(irq_valid), 32'(w[8]));
        check({tag, " R5 handler_addr"}, handler_addr,
              w[8] ? {16'h4000, vmodel[w[2:0]]} : 32'h0);
        rd(5'h10, 1'b0, d);
        check({tag, " R1 accept group"}, 32'(d), 32'({w[7:3], 2'b00}));
    endtask

    initial begin
        logic [15:0] d;
        repeat (3) tick();
        check("R3 reset irq_valid", 32'(irq_valid), 32'd0);
        check("R9 reset rvalid", 32'(reg_rvalid), 32'd0);
        rst_n = 1'b1;
        tick();
        check("R3 reset addr", handler_addr, 32'h0);

        for (int n = 0; n < 7; n++) begin
            vmodel[n] = 16'h1000 + 16'(n * 16'h0111);
            wr(5'(2*n), vmodel[n], 1'b0);
        end
        for (int n = 0; n < 7; n++) begin
            rd(5'(2*n), 1'b0, d);
            check("R6 vector readback", 32'(d), 32'(vmodel[n]));
        end
        tick();
        check("R9 rvalid drops", 32'(reg_rvalid), 32'd0);

        // R3: nothing pending
        pend_i = '0; mask_i = 3'd7;
        check_outputs("R3 none");
        // R2: mask 0 accepts nothing
        pend_i = '1; lvl_i = '0; mask_i = 3'd0;
        check_outputs("R2 mask0");
        // R2: level 7 never accepted
        lvl_i = '1; mask_i = 3'd7;
        check_outputs("R2 lvl7");
        // R2 boundary: level 6 under mask 7, level equal to mask rejected
        pend_i = '0; pend_i[5] = 1'b1; pend_i[9] = 1'b1;
        lvl_i[5*3 +: 3] = 3'd7; lvl_i[9*3 +: 3] = 3'd6;
        check_outputs("R2 lvl6");
        mask_i = 3'd6;
        check_outputs("R2 equal");
        // R1: highest group number
        pend_i = '0; pend_i[NG-1] = 1'b1; lvl_i[(NG-1)*3 +: 3] = 3'd0; mask_i = 3'd1;
        check_outputs("R1 top");

        // R8 byte reads of accept group (group 23 -> 0x5C)
        rd(5'h10, 1'b1, d);
        check("R8 low byte", 32'(d), 32'h5C);
        rd(5'h11, 1'b1, d);
        check("R8 high byte", 32'(d), 32'h0);
        rd(5'h03, 1'b1, d);
        check("R8 vector high byte", 32'(d), 32'(vmodel[1][15:8]));

        // R7 write to accept group ignored
        wr(5'h10, 16'hFFFF, 1'b0);
        rd(5'h10, 1'b0, d);
        check("R7 accept unchanged", 32'(d), 32'h5C);
        for (int n = 0; n < 7; n++) begin
            rd(5'(2*n), 1'b0, d);
            check("R7 vector unchanged", 32'(d), 32'(vmodel[n]));
        end

        // R10 byte write to vector ignored
        wr(5'h04, 16'hBEEF, 1'b1);
        rd(5'h04, 1'b0, d);
        check("R10 byte write ignored", 32'(d), 32'(vmodel[2]));

        // random
        for (int it = 0; it < 300; it++) begin
            if (it % 37 == 0) begin
                int k;
                k = int'($urandom % 7);
                vmodel[k] = 16'($urandom);
                wr(5'(2*k), vmodel[k], 1'b0);
            end
            pend_i = NG'($urandom) & NG'($urandom);
            lvl_i  = {$urandom, $urandom, $urandom};
            lvl_i  = lvl_i[NG*3-1:0];
            mask_i = 3'($urandom);
            check_outputs("rand");
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        process::self().srandom(32'd1234);
    end
endmodule